// File: doc/BRIEF.md
# Fractional-N Feedback Divider with Reference Divider

This block forms the feedback path of a fractional-N synthesizer channel. It runs on the VCO-side clock and divides it by a total ratio of 16·N + A + F/13. A 10-bit main count N sets the number of prescaler cycles in each comparison period. A 4-bit swallow count A sets how many of those cycles run at the high modulus. A modulo-13 accumulator adds F once per period. When the accumulator overflows, that period swallows one extra count, so the period lasts one VCO clock longer. The block drives the modulus-control line of a 16/17 dual-modulus prescaler. That prescaler is modelled inside the block as a synthesizable counter, and its output tick is brought out. The block also emits a one-cycle comparison pulse at the end of each period.

A second, independent section runs on the oscillator clock. It divides that clock by a 7-bit ratio R and emits a one-cycle reference pulse every R oscillator cycles. The two pulse trains are the two inputs of a phase detector.

The divider is controlled by a three-state machine:
- CTL_LOAD is entered after reset and lasts one cycle. It loads the counters and moves to CTL_SWALLOW, or to CTL_MAIN if the swallow load is zero.
- In CTL_SWALLOW the prescaler divides by 17. The machine moves to CTL_MAIN on the prescaler tick that uses up the swallow count.
- In CTL_MAIN the prescaler divides by 16.
- At every period boundary both counters reload, and the machine re-enters CTL_SWALLOW or CTL_MAIN.

The reference section has two states. REF_LOAD runs once after reset, and REF_COUNT wraps at zero on every reference pulse.

Top module: `frac_fb_divider`

## Requirements
- R1: With settings N (18..1023), A (A < N−2) and F (F < 13) held constant, every period between consecutive `fp_pulse` assertions lasts either 16·N + A or 16·N + A + 1 cycles of `clk_vco`.
- R2: Any 13 consecutive periods at constant settings sum to exactly 13·(16·N + A) + F cycles of `clk_vco`.
- R3: With F = 0, every period lasts exactly 16·N + A cycles.
- R4: Within a period, `mod_hi` is high for exactly 17·(A + c) cycles, where c is 1 in a period lengthened by an accumulator overflow and 0 otherwise. It is low for the rest of the period.
- R5: While `mod_hi` is high, `pre_tick` pulses once every 17 cycles. While it is low, `pre_tick` pulses once every 16 cycles. `mod_hi` changes only right after a tick.
- R6: `fp_pulse` is high for exactly one `clk_vco` cycle per period.
- R7: A change of N, A or F made partway through a period does not alter the length of that period. The new values apply from the next period.
- R8: `fr_pulse` is high for one `clk_osc` cycle every R cycles, for any R from 3 to 127.
- R9: While `rst_n` is low, `fp_pulse`, `fr_pulse`, `mod_hi` and `pre_tick` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | VCO-side clock that is divided |
| clk_osc | input | 1 | Oscillator clock for the reference divider |
| rst_n | input | 1 | Asynchronous active-low reset for both sections |
| n_div | input | 10 | Main count N, legal range 18..1023 |
| a_swal | input | 4 | Swallow count A, must satisfy A < N−2 |
| f_num | input | 4 | Fractional numerator F, must be below 13 |
| r_div | input | 7 | Reference ratio R, legal range 3..127 |
| mod_hi | output | 1 | Prescaler modulus control: 1 selects divide-by-17, 0 selects divide-by-16 |
| pre_tick | output | 1 | One-cycle pulse at the end of each prescaler cycle |
| fp_pulse | output | 1 | One-cycle comparison pulse at the end of each feedback period |
| fr_pulse | output | 1 | One-cycle reference pulse every R oscillator cycles |

## Verification
The assertions assume that N, A and F always lie in their legal ranges. That assumption is what keeps the swallow count finished before the main count ends, and keeps the accumulator below 13. The reference assertion likewise assumes R of at least 2. The directed stimulus changes the inputs only on falling clock edges, and only to legal combinations, including the extremes N = 18 with A = 15 and F = 12, N = 1023, and R = 3 and R = 127. Every period measured after a settings change is preceded by one discarded period. That way, each measurement window contains only period boundaries taken with the new values.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

    // Default prescaler low modulus and fractional modulus
    localparam int PRE_BASE = 16;
    localparam int FRAC_Q   = 13;

    // Feedback control machine
    typedef enum logic [1:0] {
        CTL_LOAD    = 2'd0,
        CTL_SWALLOW = 2'd1,
        CTL_MAIN    = 2'd2
    } ctl_state_t;

    // Reference divider machine
    typedef enum logic {
        REF_LOAD  = 1'b0,
        REF_COUNT = 1'b1
    } ref_state_t;

endpackage

// File: rtl/fnd_prescaler.sv
module fnd_prescaler #(
    parameter int LOW_MOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mod_hi,
    output logic tick
);
    localparam int PC_W = $clog2(LOW_MOD + 1);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] last_val;

    // Last count of the current prescaler cycle depends on modulus
    always_comb begin
        last_val = mod_hi ? PC_W'(LOW_MOD) : PC_W'(LOW_MOD - 1);
        tick     = run && (pc_q == last_val);
        if (!run) begin
            pc_d = '0;
        end else if (tick) begin
            pc_d = '0;
        end else begin
            pc_d = pc_q + PC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    // A tick is always followed by a fresh count from zero
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick) else $error("prescaler tick lasted two cycles"); // R5

endmodule

// File: rtl/fnd_frac_acc.sv
module fnd_frac_acc #(
    parameter int MODQ = 13,
    parameter int F_W  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic [F_W-1:0] f_val,
    output logic           carry
);
    localparam int ACC_W = $clog2(MODQ);
    localparam int SUM_W = ((ACC_W > F_W) ? ACC_W : F_W) + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [SUM_W-1:0] sum;

    // carry is combinational: it must reach the swallow reload on the
    // same edge that steps the accumulator
    always_comb begin
        sum   = SUM_W'(acc_q) + SUM_W'(f_val);
        carry = (sum >= SUM_W'(MODQ));
        if (!step) begin
            acc_d = acc_q;
        end else if (carry) begin
            acc_d = ACC_W'(sum - SUM_W'(MODQ));
        end else begin
            acc_d = ACC_W'(sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // Residue stays inside the modulus when the numerator is legal
    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < ACC_W'(MODQ)) else $error("accumulator left its modulus"); // R2

endmodule

// File: rtl/fnd_swallow_ctl.sv
module fnd_swallow_ctl
    import fnd_pkg::*;
#(
    parameter int N_W = 10,
    parameter int A_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_tick,
    input  logic [N_W-1:0] n_val,
    input  logic [A_W-1:0] a_val,
    input  logic           carry_in,
    output logic           mod_hi,
    output logic           run,
    output logic           step,
    output logic           fp_q
);
    localparam int S_W = A_W + 1;

    ctl_state_t     st_q, st_d;
    logic [N_W-1:0] main_q, main_d;
    logic [S_W-1:0] swal_q, swal_d;
    logic [S_W-1:0] swal_load;
    logic           boundary;

    // Period boundary: last prescaler tick of the main count
    always_comb begin
        swal_load = S_W'(a_val) + S_W'(carry_in);
        boundary  = (st_q != CTL_LOAD) && pre_tick && (main_q == N_W'(1));
        step      = (st_q == CTL_LOAD) || boundary;
    end

    // Next-state process
    always_comb begin
        st_d   = st_q;
        main_d = main_q;
        swal_d = swal_q;
        unique case (st_q)
            CTL_LOAD: begin
                main_d = n_val;
                swal_d = swal_load;
                st_d   = (swal_load != '0) ? CTL_SWALLOW : CTL_MAIN;
            end
            CTL_SWALLOW: begin
                if (boundary) begin
                    main_d = n_val;
                    swal_d = swal_load;
                    st_d   = (swal_load != '0) ? CTL_SWALLOW : CTL_MAIN;
                end else if (pre_tick) begin
                    main_d = main_q - N_W'(1);
                    swal_d = swal_q - S_W'(1);
                    if (swal_q == S_W'(1)) begin
                        st_d = CTL_MAIN;
                    end
                end
            end
            CTL_MAIN: begin
                if (boundary) begin
                    main_d = n_val;
                    swal_d = swal_load;
                    st_d   = (swal_load != '0) ? CTL_SWALLOW : CTL_MAIN;
                end else if (pre_tick) begin
                    main_d = main_q - N_W'(1);
                end
            end
            default: begin
                st_d = CTL_LOAD;
            end
        endcase
    end

    // Output process
    always_comb begin
        mod_hi = (st_q == CTL_SWALLOW);
        run    = (st_q != CTL_LOAD);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CTL_LOAD;
            main_q <= '0;
            swal_q <= '0;
            fp_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            main_q <= main_d;
            swal_q <= swal_d;
            fp_q   <= boundary;
        end
    end

    AST_SWAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |-> (st_q == CTL_MAIN)) else $error("swallow still active at period end"); // R4

    AST_MOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pre_tick) |=> $stable(mod_hi)) else $error("modulus changed mid prescaler cycle"); // R5

    AST_FP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fp_q |=> !fp_q) else $error("comparison pulse wider than one cycle"); // R6

    AST_MAIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (main_q != '0)) else $error("main count reached zero while running"); // R1

endmodule

// File: rtl/fnd_ref_div.sv
module fnd_ref_div
    import fnd_pkg::*;
#(
    parameter int R_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] r_val,
    output logic           fr_q
);
    ref_state_t     st_q, st_d;
    logic [R_W-1:0] cnt_q, cnt_d;
    logic           fr_d;

    // Next-state process
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fr_d  = 1'b0;
        unique case (st_q)
            REF_LOAD: begin
                cnt_d = r_val - R_W'(1);
                st_d  = REF_COUNT;
            end
            REF_COUNT: begin
                if (cnt_q == '0) begin
                    cnt_d = r_val - R_W'(1);
                    fr_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q - R_W'(1);
                end
            end
            default: begin
                st_d = REF_LOAD;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= REF_LOAD;
            cnt_q <= '0;
            fr_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            fr_q  <= fr_d;
        end
    end

    AST_FR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q |=> !fr_q) else $error("reference pulse wider than one cycle"); // R8

endmodule

// File: rtl/frac_fb_divider.sv
module frac_fb_divider
    import fnd_pkg::*;
#(
    parameter int N_W      = 10,
    parameter int A_W      = 4,
    parameter int F_W      = 4,
    parameter int R_W      = 7,
    parameter int PRE_LOW  = PRE_BASE,
    parameter int FRAC_MOD = FRAC_Q,
    parameter int N_MIN    = 18
) (
    input  logic           clk_vco,
    input  logic           clk_osc,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_div,
    input  logic [A_W-1:0] a_swal,
    input  logic [F_W-1:0] f_num,
    input  logic [R_W-1:0] r_div,
    output logic           mod_hi,
    output logic           pre_tick,
    output logic           fp_pulse,
    output logic           fr_pulse
);
    logic run;
    logic step;
    logic carry;

    fnd_prescaler #(
        .LOW_MOD (PRE_LOW)
    ) u_pre (
        .clk    (clk_vco),
        .rst_n  (rst_n),
        .run    (run),
        .mod_hi (mod_hi),
        .tick   (pre_tick)
    );

    fnd_frac_acc #(
        .MODQ (FRAC_MOD),
        .F_W  (F_W)
    ) u_acc (
        .clk   (clk_vco),
        .rst_n (rst_n),
        .step  (step),
        .f_val (f_num),
        .carry (carry)
    );

    fnd_swallow_ctl #(
        .N_W (N_W),
        .A_W (A_W)
    ) u_ctl (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .pre_tick (pre_tick),
        .n_val    (n_div),
        .a_val    (a_swal),
        .carry_in (carry),
        .mod_hi   (mod_hi),
        .run      (run),
        .step     (step),
        .fp_q     (fp_pulse)
    );

    fnd_ref_div #(
        .R_W (R_W)
    ) u_ref (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .r_val (r_div),
        .fr_q  (fr_pulse)
    );

    // Input legality the divider relies on
    AST_SET_LEGAL: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (int'(n_div) >= N_MIN) && (int'(a_swal) + 2 < int'(n_div)) && (int'(f_num) < FRAC_MOD))
        else $error("illegal divider settings"); // R1

endmodule

// File: tb/frac_fb_divider_tb_top.sv
`timescale 1ns/1ps
module frac_fb_divider_tb_top;

    logic       clk_vco = 1'b0;
    logic       clk_osc = 1'b0;
    logic       rst_n   = 1'b0;
    logic [9:0] n_div   = 10'd20;
    logic [3:0] a_swal  = 4'd3;
    logic [3:0] f_num   = 4'd0;
    logic [6:0] r_div   = 7'd3;
    logic       mod_hi, pre_tick, fp_pulse, fr_pulse;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk_vco = ~clk_vco;
    always #20  clk_osc = ~clk_osc;

    frac_fb_divider dut_i (
        .clk_vco  (clk_vco),
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .n_div    (n_div),
        .a_swal   (a_swal),
        .f_num    (f_num),
        .r_div    (r_div),
        .mod_hi   (mod_hi),
        .pre_tick (pre_tick),
        .fp_pulse (fp_pulse),
        .fr_pulse (fr_pulse)
    );

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Measures one period starting at a falling edge where fp_pulse is high
    task automatic measure_fp(output int len, output int hi);
        while (!fp_pulse) @(negedge clk_vco);
        len = 0;
        hi  = 0;
        do begin
            len++;
            if (mod_hi) hi++;
            @(negedge clk_vco);
        end while (!fp_pulse);
    endtask

    task automatic set_fb(input int n, input int a, input int f);
        @(negedge clk_vco);
        n_div  = 10'(n);
        a_swal = 4'(a);
        f_num  = 4'(f);
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk_vco);
        chk("R9 fp_pulse in reset", fp_pulse, 0);
        chk("R9 mod_hi in reset", mod_hi, 0);
        chk("R9 pre_tick in reset", pre_tick, 0);
        chk("R9 fr_pulse in reset", fr_pulse, 0);
        @(negedge clk_vco);
        rst_n = 1'b1;
    endtask

    // 13-period window at fixed settings
    task automatic t_window(input int n, input int a, input int f);
        int len, hi, base, c, exp_len;
        longint sum;
        set_fb(n, a, f);
        measure_fp(len, hi);
        base = 16 * n + a;
        sum  = 0;
        for (int i = 0; i < 13; i++) begin
            measure_fp(len, hi);
            sum += len;
            c = len - base;
            exp_len = (c == 1) ? base + 1 : base;
            chk("R1 period length", len, exp_len);
            chk("R4 high-modulus span", hi, 17 * (a + exp_len - base));
            if (f == 0) chk("R3 integer period", len, base);
        end
        chk("R2 thirteen-period sum", sum, 13 * base + f);
    endtask

    task automatic t_midchange;
        int len, hi;
        set_fb(20, 3, 0);
        measure_fp(len, hi);
        len = 0;
        do begin
            len++;
            if (len == 50) begin
                n_div  = 10'd25;
                a_swal = 4'd7;
            end
            @(negedge clk_vco);
        end while (!fp_pulse);
        chk("R7 period holding old settings", len, 16 * 20 + 3);
        measure_fp(len, hi);
        chk("R7 period with new settings", len, 16 * 25 + 7);
    endtask

    task automatic tick_gap(output int gap);
        int len, hi;
        measure_fp(len, hi);
        while (!pre_tick) @(negedge clk_vco);
        @(negedge clk_vco);
        gap = 1;
        while (!pre_tick) begin
            gap++;
            @(negedge clk_vco);
        end
    endtask

    task automatic t_ticks;
        int gap, len, hi;
        set_fb(25, 7, 0);
        measure_fp(len, hi);
        tick_gap(gap);
        chk("R5 tick spacing at 17", gap, 17);
        set_fb(25, 0, 0);
        measure_fp(len, hi);
        tick_gap(gap);
        chk("R5 tick spacing at 16", gap, 16);
    endtask

    task automatic t_long;
        int len, hi;
        set_fb(1023, 0, 0);
        measure_fp(len, hi);
        measure_fp(len, hi);
        chk("R1 maximum main count", len, 16 * 1023);
    endtask

    task automatic t_ref(input int r);
        int p;
        @(negedge clk_osc);
        r_div = 7'(r);
        while (!fr_pulse) @(negedge clk_osc);
        @(negedge clk_osc);
        while (!fr_pulse) @(negedge clk_osc);
        p = 0;
        do begin
            p++;
            @(negedge clk_osc);
        end while (!fr_pulse);
        chk("R8 reference period", p, r);
    endtask

    initial begin
        repeat (190000) @(posedge clk_vco);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_window(20, 3, 0);
        t_window(20, 3, 5);
        t_window(18, 15, 12);
        t_midchange();
        t_ticks();
        t_long();
        t_ref(3);
        t_ref(52);
        t_ref(127);
        finish_run();
    end

endmodule